// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block steps through the word addresses of one synchronous burst read from a memory array. The host pulses a start strobe together with a start address. The block then presents one word address per accepted beat, with a valid flag. The host accepts a beat by holding an advance input high. Configuration inputs select the following:

- the burst length: four words, eight words, or continuous to the end of a partition;
- whether a fixed burst wraps inside its aligned block or runs straight past it;
- linear or interleaved ordering inside the block;
- when the active-low wait line falls;
- which clock edge the block acts on.

In the linear, non-wrapping modes (continuous, or a fixed length with wrapping off), the block models the array's refill penalty. The first time the addresses step over a 64-word boundary, the block inserts a single stall. The stall lasts longer the closer the start lies to the end of its 64-word block, and it reaches the full latency setting when the burst starts on the last word. During the stall, valid is low and the wait line tells the host to hold off. A burst-done pulse follows the final word. The configuration and the start address are captured with the strobe, and a new strobe abandons any burst still running.

Top module: `bseq_burst_seq`

## Requirements
- R1: After reset, valid_o and done_o are 0 and wait_n_o is 1.
- R2: Length code 001 gives 4 words, 010 gives 8 words and 111 gives a continuous burst. Any other code gives a 4-word linear wrapping burst.
- R3: With cfg_nowrap_i = 0 and cfg_linear_i = 1, a fixed burst visits the aligned 4- or 8-word block from the start offset upward and wraps to the block's first word. For example, offset 2 of 4 gives 2,3,0,1.
- R4: With cfg_linear_i = 0 (and cfg_nowrap_i = 0), the word offset is the start offset XOR the beat number inside the aligned block. A continuous burst ignores this bit and stays linear.
- R5: With cfg_nowrap_i = 1, a fixed burst counts start, start+1, and so on across the block boundary. cfg_nowrap_i = 1 together with cfg_linear_i = 0 is illegal and runs as a 4-word linear wrapping burst.
- R6: A continuous burst ends after the last word of its 2^PART_W-word partition. After the final word of any burst is accepted, done_o is 1 for one cycle with valid_o at 0.
- R7: In continuous or non-wrapping mode, the first step from an address with low six bits 63 to the next address inserts S cycles with valid_o at 0. Here S = max(0, lat - (63 - off)) and off = start mod 64, and S = 0 when off = 0. This happens at most once per burst.
- R8: With cfg_wait_early_i = 0, wait_n_o is 0 exactly in the stall cycles. With cfg_wait_early_i = 1, wait_n_o is 0 from the cycle that presents the word before the crossing through the stall's second-to-last cycle.
- R9: The address steps only on active edges where valid_o and adv_i are both 1. Otherwise address and valid_o hold.
- R10: Configuration and start address are captured on the start edge, and later changes to them do not affect the running burst. A new start abandons the current burst.
- R11: cfg_fall_edge_i = 0 makes the block act on the rising edge of clk, and 1 makes it act on the falling edge.
- R12: The first word (the start address, valid_o = 1) appears right after the active edge that samples start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, begins a new burst |
| start_addr_i | input | ADDR_W | First word address of the burst |
| cfg_len_i | input | 3 | Burst length code |
| cfg_nowrap_i | input | 1 | 1 = run across the burst block boundary |
| cfg_linear_i | input | 1 | 1 = linear order, 0 = interleaved order |
| cfg_wait_early_i | input | 1 | 1 = wait falls one cycle ahead of the stall |
| cfg_fall_edge_i | input | 1 | 1 = act on the falling clock edge |
| cfg_lat_i | input | LAT_W | Latency setting, the worst-case stall length |
| adv_i | input | 1 | Host accepts the current word |
| addr_o | output | ADDR_W | Current word address |
| valid_o | output | 1 | addr_o holds a word for the host |
| wait_n_o | output | 1 | Active-low hold-off to the host |
| done_o | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds the block with ADDR_W = 12, PART_W = 8 and LAT_W = 4. The 256-word partition keeps continuous bursts short enough to run to the partition end several times: from an unaligned start, from an aligned start, and with the order bit cleared. A four-bit latency allows a stall of up to 15 cycles, so the 8-word non-wrapping case can show a long stall. Both wait timings are exercised across the 64-word crossing. EDGE_SEL_EN and INTERLEAVE_EN are left at 1, so the falling-edge variant and interleaved order are built and checked.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic [1:0] {
      MODE_WRAP_LIN,
      MODE_WRAP_INT,
      MODE_NOWRAP,
      MODE_CONT
   } bmode_e;

   typedef struct packed {
      bmode_e mode;
      logic   len8;
      logic   wait_early;
   } bcfg_t;

   localparam logic [2:0] LEN_CODE_4    = 3'b001;
   localparam logic [2:0] LEN_CODE_8    = 3'b010;
   localparam logic [2:0] LEN_CODE_CONT = 3'b111;

   localparam int BLK_W = 6;

endpackage

// File: rtl/bseq_mode_dec.sv
module bseq_mode_dec
   import bseq_pkg::*;
(
   input  logic [2:0] len_i,
   input  logic       nowrap_i,
   input  logic       linear_i,
   input  logic       wait_early_i,
   output bcfg_t      cfg_o
);

   always_comb begin
      cfg_o.wait_early = wait_early_i;
      cfg_o.len8       = 1'b0;
      cfg_o.mode       = MODE_WRAP_LIN;
      if (len_i == LEN_CODE_CONT) begin
         cfg_o.mode = MODE_CONT;
      end else if ((len_i == LEN_CODE_4) || (len_i == LEN_CODE_8)) begin
         if (nowrap_i && !linear_i) begin
            cfg_o.mode = MODE_WRAP_LIN;
         end else begin
            cfg_o.len8 = (len_i == LEN_CODE_8);
            if (nowrap_i)
               cfg_o.mode = MODE_NOWRAP;
            else if (linear_i)
               cfg_o.mode = MODE_WRAP_LIN;
            else
               cfg_o.mode = MODE_WRAP_INT;
         end
      end
   end

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
   import bseq_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  bmode_e            mode_i,
   input  logic              len8_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic [ADDR_W-1:0] beat_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int OFF_W = 3;

   logic [OFF_W-1:0]  mask;
   logic [OFF_W-1:0]  off;
   logic [OFF_W-1:0]  lin_off;
   logic [OFF_W-1:0]  alt_off;
   logic [ADDR_W-1:0] base;

   always_comb begin
      mask    = len8_i ? 3'b111 : 3'b011;
      off     = start_i[OFF_W-1:0] & mask;
      lin_off = (off + beat_i[OFF_W-1:0]) & mask;
      base    = start_i & ~{{(ADDR_W-OFF_W){1'b0}}, mask};
   end

   generate
      if (INTERLEAVE_EN) begin : g_xor_order
         assign alt_off = (off ^ beat_i[OFF_W-1:0]) & mask;
      end else begin : g_lin_only
         assign alt_off = lin_off;
      end
   endgenerate

   always_comb begin
      unique case (mode_i)
         MODE_NOWRAP,
         MODE_CONT:     addr_o = start_i + beat_i;
         MODE_WRAP_INT: addr_o = base | {{(ADDR_W-OFF_W){1'b0}}, alt_off};
         default:       addr_o = base | {{(ADDR_W-OFF_W){1'b0}}, lin_off};
      endcase
   end

endmodule

// File: rtl/bseq_stall_ctl.sv
module bseq_stall_ctl
   import bseq_pkg::*;
#(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [BLK_W-1:0] start_off_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             wait_early_i,
   input  logic             at_edge_i,
   input  logic             adv_i,
   output logic             stall_o,
   output logic             wait_n_o
);

   localparam int DW = BLK_W + 1;

   logic [LAT_W-1:0] amt_q, cnt_q, amt_d;
   logic             used_q, early_q;
   logic [DW-1:0]    gap, lat_x, diff;
   logic             pending;

   always_comb begin
      gap   = {1'b0, ~start_off_i};
      lat_x = {{(DW-LAT_W){1'b0}}, lat_i};
      diff  = lat_x - gap;
      amt_d = ((start_off_i != '0) && (lat_x > gap)) ? diff[LAT_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         amt_q   <= '0;
         cnt_q   <= '0;
         used_q  <= 1'b0;
         early_q <= 1'b0;
      end else if (start_i) begin
         amt_q   <= amt_d;
         cnt_q   <= '0;
         used_q  <= 1'b0;
         early_q <= wait_early_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end else if (at_edge_i && adv_i && !used_q) begin
         used_q <= 1'b1;
         cnt_q  <= amt_q;
      end
   end

   assign pending  = at_edge_i && !used_q && (amt_q != '0);
   assign stall_o  = (cnt_q != '0);
   assign wait_n_o = early_q ? !(pending || (cnt_q > 1)) : !stall_o;

   // R7
   stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R7
   stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (used_q && !start_i && !stall_o) |=> !stall_o);

endmodule

// File: rtl/bseq_burst_seq.sv
module bseq_burst_seq
   import bseq_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int PART_W        = 10,
   parameter int LAT_W         = 4,
   parameter bit EDGE_SEL_EN   = 1'b1,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [2:0]        cfg_len_i,
   input  logic              cfg_nowrap_i,
   input  logic              cfg_linear_i,
   input  logic              cfg_wait_early_i,
   input  logic              cfg_fall_edge_i,
   input  logic [LAT_W-1:0]  cfg_lat_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              valid_o,
   output logic              wait_n_o,
   output logic              done_o
);

   localparam logic [BLK_W-1:0] BLK_LAST = '1;

   generate
      if (PART_W < BLK_W || PART_W > ADDR_W) begin : g_bad_part
         $error("PART_W must lie between the 64-word block width and ADDR_W");
      end
      if (LAT_W < 1 || LAT_W > BLK_W) begin : g_bad_lat
         $error("LAT_W must be 1 to 6");
      end
   endgenerate

   logic core_clk;

   generate
      if (EDGE_SEL_EN) begin : g_edge_sel
         assign core_clk = clk ^ cfg_fall_edge_i;
      end else begin : g_rise_only
         assign core_clk = clk;
      end
   endgenerate

   bcfg_t             cfg_d, cfg_q;
   logic              active_q, done_q;
   logic [ADDR_W-1:0] beat_q, start_q, addr_w;
   logic              elig, last_w, stall_w, valid_w, at_edge_w, step_w;

   bseq_mode_dec u_dec (
      .len_i        (cfg_len_i),
      .nowrap_i     (cfg_nowrap_i),
      .linear_i     (cfg_linear_i),
      .wait_early_i (cfg_wait_early_i),
      .cfg_o        (cfg_d)
   );

   bseq_addr_gen #(
      .ADDR_W        (ADDR_W),
      .INTERLEAVE_EN (INTERLEAVE_EN)
   ) u_gen (
      .mode_i  (cfg_q.mode),
      .len8_i  (cfg_q.len8),
      .start_i (start_q),
      .beat_i  (beat_q),
      .addr_o  (addr_w)
   );

   always_comb begin
      elig      = (cfg_q.mode == MODE_NOWRAP) || (cfg_q.mode == MODE_CONT);
      last_w    = (cfg_q.mode == MODE_CONT) ? (&addr_w[PART_W-1:0])
                : (beat_q[2:0] == (cfg_q.len8 ? 3'd7 : 3'd3));
      valid_w   = active_q && !stall_w;
      at_edge_w = valid_w && elig && (addr_w[BLK_W-1:0] == BLK_LAST) && !last_w;
      step_w    = valid_w && adv_i;
   end

   bseq_stall_ctl #(.LAT_W(LAT_W)) u_stall (
      .clk          (core_clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .start_off_i  (start_addr_i[BLK_W-1:0]),
      .lat_i        (cfg_lat_i),
      .wait_early_i (cfg_d.wait_early),
      .at_edge_i    (at_edge_w),
      .adv_i        (adv_i),
      .stall_o      (stall_w),
      .wait_n_o     (wait_n_o)
   );

   always_ff @(posedge core_clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         beat_q   <= '0;
         start_q  <= '0;
         cfg_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         done_q   <= 1'b0;
         beat_q   <= '0;
         start_q  <= start_addr_i;
         cfg_q    <= cfg_d;
      end else begin
         done_q <= 1'b0;
         if (step_w) begin
            if (last_w) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end else begin
               beat_q <= beat_q + 1'b1;
            end
         end
      end
   end

   assign addr_o  = addr_w;
   assign valid_o = valid_w;
   assign done_o  = done_q;

   // R12
   start_load_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      start_i |=> (valid_o && addr_o == $past(start_addr_i)));

   // R9
   hold_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      (valid_o && !adv_i && !start_i) |=> (valid_o && $stable(addr_o)));

   // R6
   done_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      done_o |-> (!valid_o && $past(valid_o && adv_i)));

   // R8
   wait_late_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      (!cfg_q.wait_early && !wait_n_o) |-> !valid_o);

   // R3
   wrap_block_chk: assert property (@(posedge core_clk) disable iff (!rst_n)
      (valid_o && (cfg_q.mode == MODE_WRAP_LIN || cfg_q.mode == MODE_WRAP_INT))
      |-> (addr_o[ADDR_W-1:3] == start_q[ADDR_W-1:3]));

endmodule

// File: tb/bseq_burst_seq_bench.sv
module bseq_burst_seq_bench;

   localparam int AW = 12;
   localparam int PW = 8;
   localparam int LW = 4;

   typedef struct packed {
      logic          cmp_addr;
      logic          valid;
      logic [AW-1:0] addr;
      logic          wait_n;
      logic          done;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [2:0]    len = 3'b001;
   logic          nowrap = 1'b0, linear = 1'b1, early = 1'b0, fall = 1'b0;
   logic [LW-1:0] lat = '0;
   logic          adv = 1'b1;
   logic [AW-1:0] addr;
   logic          valid, wait_n, done;

   item_t q[$];
   item_t tmp[$];
   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    finished = 0;

   always #2 clk = ~clk;

   bseq_burst_seq #(.ADDR_W(AW), .PART_W(PW), .LAT_W(LW)) u_bseq_burst_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
      .cfg_len_i(len), .cfg_nowrap_i(nowrap), .cfg_linear_i(linear),
      .cfg_wait_early_i(early), .cfg_fall_edge_i(fall), .cfg_lat_i(lat),
      .adv_i(adv), .addr_o(addr), .valid_o(valid), .wait_n_o(wait_n), .done_o(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // monitor: pops one expected item per cycle, sampled one ns before the next rising edge
   always begin
      item_t it;
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
         it = q.pop_front();
         chk(valid == it.valid, cur_req, "valid", valid, it.valid);
         chk(wait_n == it.wait_n, cur_req, "wait_n", wait_n, it.wait_n);
         chk(done == it.done, cur_req, "done", done, it.done);
         if (it.cmp_addr) chk(addr == it.addr, cur_req, "addr", addr, it.addr);
      end
   end

   // reference model of the requirements, fills tmp
   task automatic model(input logic [AW-1:0] sa, input logic [2:0] ln, input bit nw,
                        input bit lin, input bit er, input int lt, input int hold);
      bit cont, run, xo, used, here;
      int n, off6, amt, base, off, a;
      cont = (ln == 3'b111);
      run = 0; xo = 0; n = 4;
      if (cont) begin
         run = 1; n = (1 << PW) - (sa % (1 << PW));
      end else if (ln == 3'b001 || ln == 3'b010) begin
         if (nw && !lin) n = 4;
         else begin
            n = (ln == 3'b010) ? 8 : 4;
            run = nw; xo = !lin && !nw;
         end
      end
      off6 = sa % 64;
      amt = (off6 != 0 && lt > 63 - off6) ? lt - (63 - off6) : 0;
      base = sa - (sa % n);
      off = sa % n;
      used = 0;
      tmp.delete();
      for (int b = 0; b < n; b++) begin
         a = run ? (sa + b) : (xo ? base + (off ^ b) : base + ((off + b) % n));
         a = a % (1 << AW);
         here = run && (a % 64 == 63) && (b != n - 1) && !used && (amt > 0);
         tmp.push_back('{1'b1, 1'b1, a[AW-1:0], !(er && here), 1'b0});
         if (b == 0)
            for (int h = 0; h < hold; h++)
               tmp.push_back('{1'b1, 1'b1, a[AW-1:0], 1'b1, 1'b0});
         if (here) begin
            used = 1;
            for (int k = 0; k < amt; k++)
               tmp.push_back('{1'b0, 1'b0, '0, er ? (k == amt - 1) : 1'b0, 1'b0});
         end
      end
      tmp.push_back('{1'b0, 1'b0, '0, 1'b1, 1'b1});
   endtask

   task automatic run(input string req, input logic [AW-1:0] sa, input logic [2:0] ln,
                      input bit nw, input bit lin, input bit er, input int lt,
                      input int keep, input int hold);
      model(sa, ln, nw, lin, er, lt, hold);
      if (keep > 0) while (tmp.size() > keep) void'(tmp.pop_back());
      @(posedge clk); #1;
      cur_req = req;
      start_addr = sa; len = ln; nowrap = nw; linear = lin; early = er; lat = lt[LW-1:0];
      start = 1'b1;
      if (fall) foreach (tmp[i]) q.push_back(tmp[i]);
      @(posedge clk); #1;
      start = 1'b0;
      // R10: scramble the configuration once the burst is running
      start_addr = ~sa; len = 3'b000; nowrap = ~nw; linear = ~lin; early = ~er;
      lat = ~lt[LW-1:0];
      if (hold > 0) adv = 1'b0;
      if (!fall) foreach (tmp[i]) q.push_back(tmp[i]);
      if (hold > 0) begin
         repeat (hold) @(posedge clk);
         #1 adv = 1'b1;
      end
      if (keep == 0) while (q.size() > 0) @(posedge clk);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #3;
      // R1 reset state
      chk(valid == 1'b0, "R1", "valid", valid, 0);
      chk(wait_n == 1'b1, "R1", "wait_n", wait_n, 1);
      chk(done == 1'b0, "R1", "done", done, 0);

      // R3 R12 4-word linear wrap from offset 2
      run("R3", 12'h0A2, 3'b001, 0, 1, 0, 0, 0, 0);
      // R3 8-word linear wrap
      run("R3", 12'h0B5, 3'b010, 0, 1, 0, 0, 0, 0);
      // R4 interleaved 8 and 4 words
      run("R4", 12'h0B5, 3'b010, 0, 0, 0, 0, 0, 0);
      run("R4", 12'h021, 3'b001, 0, 0, 0, 0, 0, 0);
      // R5 no-wrap across the 4-word block
      run("R5", 12'h003, 3'b001, 1, 1, 0, 15, 0, 0);
      // R5 illegal no-wrap with interleaved order
      run("R5", 12'h046, 3'b010, 1, 0, 0, 0, 0, 0);
      // R2 undefined length codes
      run("R2", 12'h05B, 3'b011, 0, 1, 0, 0, 0, 0);
      run("R2", 12'h077, 3'b100, 1, 1, 0, 7, 0, 0);
      // R6 R7 continuous from last word of a block, worst stall
      run("R7", 12'h03F, 3'b111, 0, 1, 0, 5, 0, 0);
      // R8 early wait, partial stall
      run("R8", 12'h13E, 3'b111, 0, 1, 1, 3, 0, 0);
      // R7 aligned continuous start: no stall; R4 continuous ignores order bit
      run("R7", 12'h100, 3'b111, 0, 0, 0, 15, 0, 0);
      // R7 R8 no-wrap 8-word crossing with long stall, late and early wait
      run("R7", 12'h03C, 3'b010, 1, 1, 0, 15, 0, 0);
      run("R8", 12'h0BC, 3'b010, 1, 1, 1, 15, 0, 0);
      // R7 no crossing: no stall
      run("R7", 12'h010, 3'b001, 1, 1, 0, 15, 0, 0);
      // R9 host holds the first word three cycles
      run("R9", 12'h008, 3'b001, 0, 1, 0, 0, 0, 3);
      // R10 abort after two words, then a fresh burst
      run("R10", 12'h020, 3'b010, 0, 1, 0, 0, 2, 0);
      run("R10", 12'h051, 3'b001, 0, 1, 0, 0, 0, 0);
      // R11 falling-edge operation
      @(posedge clk); #1 fall = 1'b1;
      @(posedge clk); #1;
      chk(valid == 1'b0, "R11", "idle valid", valid, 0);
      run("R11", 12'h0C6, 3'b010, 0, 1, 0, 0, 0, 0);
      run("R11", 12'h03E, 3'b001, 1, 1, 1, 4, 0, 0);
      @(posedge clk); #1 fall = 1'b0;
      repeat (2) @(posedge clk);
      run("R12", 12'h0E4, 3'b001, 0, 1, 0, 0, 0, 0);
      repeat (3) @(posedge clk);
      summary();
   end

endmodule